// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit performs one 32-bit atomic read-modify-write on a single-port memory bus for each request it accepts from a core. A request carries an opcode, a word address, an operand and two ordering flags (acquire and release). The unit raises a bus lock, reads the target word, combines it with the operand, writes the result back to the same address, and then drops the lock. The requester gets back the value the word held before the update. Because the lock is held from before the read until the write response arrives, no other bus master can observe or modify the word between the read and the write.

The unit handles one operation at a time. It keeps its request-ready output low from acceptance until the response is presented. A request with a misaligned address or an unknown opcode is answered with an error and no bus traffic. The ordering flags are presented on the bus during the whole locked sequence so that the memory system can apply the requested fence semantics.

Top module: `amo_unit`

## Requirements
- R1: A successful response carries on rsp_data_o the value the addressed word held just before the operation, with rsp_err_o low.
- R2: Swap (opcode 0) writes the operand unchanged.
- R3: Add (opcode 1) writes old plus operand modulo 2^32, so a carry out of bit 31 is dropped.
- R4: XOR (2), AND (3) and OR (4) write the bitwise combination of old value and operand.
- R5: Signed min (5) and signed max (6) compare both words as two's complement and write the smaller or the larger.
- R6: Unsigned min (7) and unsigned max (8) compare both words as unsigned and write the smaller or the larger.
- R7: mem_lock_o rises at least one cycle before the first memory request of an operation, mem_req_o is only high while the lock was already high in the previous cycle, and the lock falls only in the cycle after the write response.
- R8: Each valid operation issues exactly one read and then one write, both to the request address, with the write issued only after the read data has returned; a request is held stable until granted.
- R9: req_ready_o is low from acceptance until after the response cycle; exactly one single-cycle rsp_valid_o pulse follows each accepted request, and it comes after the lock has dropped.
- R10: A request whose address bits [1:0] are not 00 returns rsp_err_o high and rsp_data_o zero, raises no lock and makes no memory access.
- R11: A request with an opcode above 8 is answered like R10: error, zero data, no lock, no memory access.
- R12: mem_order_o carries {acquire, release} (bit 1 acquire, bit 0 release; 2'b11 means sequentially consistent) of the current request and stays stable while the lock is high.
- R13: After reset req_ready_o is high and rsp_valid_o, mem_req_o and mem_lock_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Unit idle and able to accept |
| req_op_i | input | 4 | Operation code |
| req_addr_i | input | AW | Byte address of the word |
| req_data_i | input | DW | Operand |
| req_aq_i | input | 1 | Acquire ordering flag |
| req_rl_i | input | 1 | Release ordering flag |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_data_o | output | DW | Pre-update memory value |
| rsp_err_o | output | 1 | Request rejected |
| mem_req_o | output | 1 | Memory request, held until granted |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_gnt_i | input | 1 | Memory grant of the current request |
| mem_rvalid_i | input | 1 | Memory response (read data or write acknowledge) |
| mem_rdata_i | input | DW | Memory read data |
| mem_lock_o | output | 1 | Bus lock |
| mem_order_o | output | 2 | Ordering flags {acquire, release} |

## Verification
Every opcode is run against stored words chosen so that the operation is visible: an add that carries out of bit 31, a negative word against a positive operand so that signed and unsigned min/max pick opposite winners, and bit patterns whose XOR, AND and OR all differ. Misaligned addresses and unknown opcodes are mixed between valid operations to show that they leave memory, lock and access count untouched. Grant latency is varied from zero to several cycles and all four ordering-flag combinations are used, which separates a correct lock and hold sequence from one that only works with an immediate grant.

// File: rtl/amo_pkg.sv
package amo_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SWAP = 4'd0,
    OP_ADD  = 4'd1,
    OP_XOR  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_MIN  = 4'd5,
    OP_MAX  = 4'd6,
    OP_MINU = 4'd7,
    OP_MAXU = 4'd8
  } amo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOCK,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_RESP
  } amo_state_e;

  function automatic logic op_supported(logic [OP_W-1:0] op);
    return op <= OP_MAXU;
  endfunction

endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   old_i,
  input  logic [DW-1:0]   opd_i,
  output logic [DW-1:0]   res_o
);

  logic lt_s, lt_u;

  assign lt_s = $signed(old_i) < $signed(opd_i);
  assign lt_u = old_i < opd_i;

  always_comb begin
    unique case (op_i)
      OP_SWAP: res_o = opd_i;
      OP_ADD:  res_o = old_i + opd_i;
      OP_XOR:  res_o = old_i ^ opd_i;
      OP_AND:  res_o = old_i & opd_i;
      OP_OR:   res_o = old_i | opd_i;
      OP_MIN:  res_o = lt_s ? old_i : opd_i;
      OP_MAX:  res_o = lt_s ? opd_i : old_i;
      OP_MINU: res_o = lt_u ? old_i : opd_i;
      OP_MAXU: res_o = lt_u ? opd_i : old_i;
      default: res_o = old_i;
    endcase
  end

endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bad_i,
  input  logic mem_gnt_i,
  input  logic mem_rvalid_i,
  output logic idle_o,
  output logic lock_o,
  output logic mem_req_o,
  output logic mem_we_o,
  output logic cap_old_o,
  output logic rsp_valid_o
);

  amo_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = bad_i ? ST_RESP : ST_LOCK;
      ST_LOCK:    state_d = ST_RD_REQ;
      ST_RD_REQ:  if (mem_gnt_i) state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (mem_rvalid_i) state_d = ST_WR_REQ;
      ST_WR_REQ:  if (mem_gnt_i) state_d = ST_WR_WAIT;
      ST_WR_WAIT: if (mem_rvalid_i) state_d = ST_RESP;
      ST_RESP:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign idle_o      = state_q == ST_IDLE;
  assign lock_o      = state_q inside {ST_LOCK, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WR_WAIT};
  assign mem_req_o   = state_q inside {ST_RD_REQ, ST_WR_REQ};
  assign mem_we_o    = state_q == ST_WR_REQ;
  assign cap_old_o   = (state_q == ST_RD_WAIT) && mem_rvalid_i;
  assign rsp_valid_o = state_q == ST_RESP;

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [OP_W-1:0] req_op_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [DW-1:0]   req_data_i,
  input  logic            req_aq_i,
  input  logic            req_rl_i,
  output logic            rsp_valid_o,
  output logic [DW-1:0]   rsp_data_o,
  output logic            rsp_err_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic            mem_gnt_i,
  input  logic            mem_rvalid_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            mem_lock_o,
  output logic [1:0]      mem_order_o
);

  localparam int unsigned OFF_W = $clog2(DW / 8);

  logic            accept, bad, cap_old;
  logic [OP_W-1:0] op_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   opd_q, old_q, new_q, alu_res;
  logic [1:0]      ord_q;
  logic            err_q;

  assign accept = req_valid_i && req_ready_o;
  assign bad    = (req_addr_i[OFF_W-1:0] != '0) || !op_supported(req_op_i);

  amo_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (accept),
    .bad_i        (bad),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .idle_o       (req_ready_o),
    .lock_o       (mem_lock_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .cap_old_o    (cap_old),
    .rsp_valid_o  (rsp_valid_o)
  );

  amo_alu #(.DW(DW)) u_alu (
    .op_i  (op_q),
    .old_i (mem_rdata_i),
    .opd_i (opd_q),
    .res_o (alu_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= '0;
      addr_q <= '0;
      opd_q  <= '0;
      ord_q  <= '0;
      err_q  <= 1'b0;
    end else if (accept) begin
      op_q   <= req_op_i;
      addr_q <= req_addr_i;
      opd_q  <= req_data_i;
      ord_q  <= {req_aq_i, req_rl_i};
      err_q  <= bad;
    end
  end

  // old value cleared on accept so a rejected request answers zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      old_q <= '0;
      new_q <= '0;
    end else if (accept) begin
      old_q <= '0;
    end else if (cap_old) begin
      old_q <= mem_rdata_i;
      new_q <= alu_res;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = new_q;
  assign mem_order_o = ord_q;
  assign rsp_data_o  = old_q;
  assign rsp_err_o   = err_q;

endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic          rsp_err_o,
  input logic [DW-1:0] rsp_data_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_gnt_i,
  input logic          mem_rvalid_i,
  input logic          mem_lock_o,
  input logic [1:0]    mem_order_o
);

  a_r7_req_under_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_lock_o);

  a_r7_lock_leads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_lock_o) |-> !mem_req_o);

  a_r7_lock_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_lock_o) |-> $past(mem_rvalid_i));

  a_r8_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o)
                                && $stable(mem_wdata_o));

  a_r9_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_lock_o |-> !req_ready_o);

  a_r9_rsp_after_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !mem_lock_o && !req_ready_o);

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r10_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_err_o |-> rsp_data_o == '0);

  a_r12_order_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_lock_o && $past(mem_lock_o) |-> $stable(mem_order_o));

endmodule

bind amo_unit amo_unit_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_err_o    (rsp_err_o),
  .rsp_data_o   (rsp_data_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_gnt_i    (mem_gnt_i),
  .mem_rvalid_i (mem_rvalid_i),
  .mem_lock_o   (mem_lock_o),
  .mem_order_o  (mem_order_o)
);

// File: tb/amo_unit_tb.sv
`timescale 1ns/1ps
module amo_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_op = '0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic        req_aq = 1'b0, req_rl = 1'b0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_data;
  logic        mem_req, mem_we, mem_gnt, mem_lock;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rvalid;
  logic [1:0]  mem_order;

  always #2.5 clk = ~clk;

  amo_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_data_i(req_data), .req_aq_i(req_aq), .req_rl_i(req_rl),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_err_o(rsp_err),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .mem_lock_o(mem_lock), .mem_order_o(mem_order)
  );

  int errors = 0, checks = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory model
  logic [31:0] mem_m [16];
  int gnt_delay = 0, stall_cnt = 0, acc_cnt = 0;
  assign mem_gnt = mem_req && (stall_cnt == 0);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      stall_cnt  <= 0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_req && mem_gnt) begin
        acc_cnt    <= acc_cnt + 1;
        mem_rvalid <= 1'b1;
        if (mem_we) mem_m[mem_addr[5:2]] <= mem_wdata;
        else        mem_rdata <= mem_m[mem_addr[5:2]];
        stall_cnt  <= gnt_delay;
      end else if (mem_req && stall_cnt > 0) begin
        stall_cnt <= stall_cnt - 1;
      end
    end
  end

  // protocol observers, sampled at negedge
  logic [31:0] cur_addr = '0;
  logic [1:0]  cur_ord = '0;
  int phase = 0, lock_rises = 0;
  int r7_viol = 0, r8_viol = 0, r9_viol = 0, r12_viol = 0;
  bit prev_lock = 1'b0, wr_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && !prev_lock) r7_viol++;
      if (mem_lock && !prev_lock) begin
        lock_rises++;
        if (mem_req) r7_viol++;
      end
      if (!mem_lock && prev_lock && !wr_done) r7_viol++;
      if (mem_lock && req_ready) r9_viol++;
      if (mem_lock && mem_order != cur_ord) r12_viol++;
      if (mem_req && mem_gnt) begin
        if (mem_addr != cur_addr) r8_viol++;
        if (phase == 0 && !mem_we) phase = 1;
        else if (phase == 2 && mem_we) phase = 3;
        else r8_viol++;
      end
      if (mem_rvalid) begin
        if (phase == 1) phase = 2;
        else if (phase == 3) begin phase = 4; wr_done = 1'b1; end
        else r8_viol++;
      end
      prev_lock = mem_lock;
    end
  end

  // scoreboard
  typedef struct {
    logic [31:0] data;
    logic        err;
    int          acc;
    int          locks;
    string       name;
  } exp_t;
  exp_t exp_q[$];
  logic [31:0] exp_mem [16];
  int exp_acc = 0, exp_locks = 0, issued = 0, rsp_cnt = 0;

  function automatic logic [31:0] model(int op, logic [31:0] a, logic [31:0] b);
    case (op)
      0: return b;
      1: return a + b;
      2: return a ^ b;
      3: return a & b;
      4: return a | b;
      5: return ($signed(a) < $signed(b)) ? a : b;
      6: return ($signed(a) > $signed(b)) ? a : b;
      7: return (a < b) ? a : b;
      default: return (a > b) ? a : b;
    endcase
  endfunction

  task automatic issue(input int op, input logic [31:0] addr, input logic [31:0] opd,
                       input bit aq, input bit rl, input string name);
    exp_t e;
    bit bad = (addr[1:0] != 2'b00) || (op > 8);
    e.name = name;
    if (bad) begin
      e.data = '0; e.err = 1'b1;
    end else begin
      e.data = exp_mem[addr[5:2]]; e.err = 1'b0;
      exp_mem[addr[5:2]] = model(op, e.data, opd);
      exp_acc += 2; exp_locks++;
    end
    e.acc = exp_acc; e.locks = exp_locks;
    exp_q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_addr = addr; cur_ord = {aq, rl}; phase = 0; wr_done = 1'b0;
    req_valid = 1'b1; req_op = op[3:0]; req_addr = addr; req_data = opd;
    req_aq = aq; req_rl = rl;
    issued++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t e;
      rsp_cnt++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected response", 32'(rsp_cnt), 32'(issued));
      end else begin
        e = exp_q.pop_front();
        check(rsp_data == e.data, {"R1 data ", e.name}, rsp_data, e.data);
        check(rsp_err == e.err, {"R10/R11 err ", e.name}, 32'(rsp_err), 32'(e.err));
        check(acc_cnt == e.acc, {"R8 access count ", e.name}, 32'(acc_cnt), 32'(e.acc));
        check(lock_rises == e.locks, {"R7 lock count ", e.name}, 32'(lock_rises), 32'(e.locks));
      end
    end
  end

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem_m[i]   = 32'h1000_0000 + 32'(i * 32'h0101_0101);
      exp_mem[i] = mem_m[i];
    end
    mem_m[1] = 32'hFFFF_FFFF;   exp_mem[1] = mem_m[1];
    mem_m[2] = 32'hF0F0_00FF;   exp_mem[2] = mem_m[2];
    mem_m[5] = 32'h8000_0010;   exp_mem[5] = mem_m[5];
    mem_m[6] = 32'hFFFF_FFF0;   exp_mem[6] = mem_m[6];

    repeat (3) @(negedge clk);
    // R13 reset state
    check(req_ready == 1'b1, "R13 ready", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R13 rsp_valid", 32'(rsp_valid), 32'd0);
    check(mem_req == 1'b0, "R13 mem_req", 32'(mem_req), 32'd0);
    check(mem_lock == 1'b0, "R13 lock", 32'(mem_lock), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    gnt_delay = 0;
    issue(0, 32'h00, 32'hDEAD_BEEF, 0, 0, "R2 swap");
    issue(1, 32'h04, 32'h0000_0002, 1, 0, "R3 add wrap");
    issue(1, 32'h08, 32'h1234_5678, 0, 1, "R3 add");
    issue(2, 32'h0C, 32'hFF00_FF00, 1, 1, "R4 xor");
    gnt_delay = 2;
    issue(3, 32'h08, 32'h0F0F_0F0F, 0, 0, "R4 and");
    issue(4, 32'h0C, 32'h0000_00F1, 1, 1, "R4 or");
    issue(5, 32'h14, 32'h0000_0005, 1, 0, "R5 smin neg");
    issue(6, 32'h18, 32'h0000_0003, 0, 1, "R5 smax");
    issue(10, 32'h20, 32'h1111_1111, 1, 1, "R11 bad opcode");
    gnt_delay = 3;
    issue(7, 32'h18, 32'h0000_0003, 0, 0, "R6 umin");
    issue(8, 32'h14, 32'h0000_0005, 1, 1, "R6 umax");
    issue(0, 32'h22, 32'h2222_2222, 0, 0, "R10 misaligned 2");
    issue(1, 32'h01, 32'h0000_0001, 1, 0, "R10 misaligned 1");
    gnt_delay = 1;
    issue(5, 32'h24, 32'h7FFF_FFFF, 0, 1, "R5 smin pos");
    issue(6, 32'h28, 32'h8000_0000, 1, 1, "R5 smax neg opd");
    issue(7, 32'h2C, 32'hFFFF_FFFF, 0, 0, "R6 umin big opd");
    issue(8, 32'h30, 32'h0000_0001, 1, 0, "R6 umax small opd");
    issue(1, 32'h00, 32'h0000_0001, 0, 0, "R1 back-to-back");
    issue(0, 32'h00, 32'h0000_0000, 1, 1, "R1 reread");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);

    for (int i = 0; i < 16; i++)
      check(mem_m[i] == exp_mem[i], $sformatf("R2-R6 memory word %0d (R4 R5 R6)", i), mem_m[i], exp_mem[i]);
    check(r7_viol == 0, "R7 lock sequencing violations", 32'(r7_viol), 32'd0);
    check(r8_viol == 0, "R8 read/write order violations", 32'(r8_viol), 32'd0);
    check(r9_viol == 0, "R9 ready while busy", 32'(r9_viol), 32'd0);
    check(rsp_cnt == issued, "R9 one response per request", 32'(rsp_cnt), 32'(issued));
    check(r12_viol == 0, "R12 ordering flags", 32'(r12_viol), 32'd0);
    check(req_ready == 1'b1 && mem_lock == 1'b0, "R13 idle after run", 32'({req_ready, mem_lock}), 32'd2);
    finish_run();
  end

endmodule